// File: doc/BRIEF.md
# Segmented Data Memory Controller

This block sits between the operand logic of a small 8-bit processor and its data storage. Each cycle it may take one access. The access carries an 8-bit byte address, a write flag, a decrement flag and a stack flag. The byte address comes from an instruction operand or from one of the pointer registers. A page register widens the lower half of the byte space (0x00–0x7F) into many 128-byte segments. The upper half (0x80–0xFF) always maps to the fixed base page. Stack-type accesses ignore the page register and always land in segment 0.

The block holds sixteen register bytes at 0xF0–0xFF. Four of them are the pointer registers: X, the stack pointer, B and the page register S. The other twelve are general-purpose bytes. It also holds on-chip RAM for the base area and for one extension segment. Byte addresses 0x80–0xEF are passed to a peripheral register port, with strobes in the same cycle. Results (read data, 16-bit physical address, unmapped flag, decrement zero flag) are registered and appear one cycle after the access.

Top module: `dmem_seg_ctrl`

## Requirements
- R1: For a non-stack access with byte address bit 7 = 0, the physical address is {S, 1'b0, addr[6:0]}. It appears on phys_addr one cycle after the access.
- R2: For byte addresses with bit 7 = 1, phys_addr is {8'h00, addr}, whatever S holds.
- R3: A stack access (acc_stack = 1) to the lower half uses segment 0. A stack write to 0xFF leaves S unchanged.
- R4: The pointer registers sit at 0xFC (X), 0xFD (SP), 0xFE (B) and 0xFF (S). They can be written and read there, and they drive ptr_x, ptr_sp, ptr_b and seg_s.
- R5: Synchronous reset sets SP to 0x6F and sets X, B and S to 0x00.
- R6: RAM is present at physical 0x0000–0x006F and at 0x0100–0x017F (segment 1). Reads return written data one cycle later, and the two segments are separate storage.
- R7: Physical 0x0070–0x007F and every segment other than 0 and 1 are unmapped. There a read returns 0x00, a write changes nothing, and unmapped is 1 in the cycle after the access. It is 0 after mapped accesses.
- R8: Byte addresses 0x80–0xEF drive ext_sel in the same cycle, along with ext_rd (read or decrement) or ext_wr (write), ext_addr = addr[6:0] and ext_wdata. ext_rdata is returned on rd_data one cycle later. Addresses at or above 0xF0 never assert ext_sel.
- R9: A write to S applies from the next access onward. The access right after the write already uses the new segment.
- R10: A decrement (acc_dec = 1, which takes precedence over acc_we) of a byte at 0xF0–0xFF stores the byte minus one, modulo 256. The new value appears on rd_data, and dec_zero = 1 exactly when that value is 0x00.
- R11: A decrement outside 0xF0–0xFF acts as a plain read. It changes no storage and gives dec_zero = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | Access is a write |
| acc_dec | input | 1 | Access is a register decrement |
| acc_stack | input | 1 | Access made through the stack pointer |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the access |
| phys_addr | output | 16 | Physical address of the last access |
| unmapped | output | 1 | Last access hit no storage |
| dec_zero | output | 1 | Last decrement produced zero |
| ptr_x | output | 8 | X pointer |
| ptr_sp | output | 8 | Stack pointer |
| ptr_b | output | 8 | B pointer |
| seg_s | output | 8 | Segment register |
| ext_sel | output | 1 | Peripheral register slot selected |
| ext_rd | output | 1 | Peripheral read strobe |
| ext_wr | output | 1 | Peripheral write strobe |
| ext_addr | output | 7 | Peripheral register offset |
| ext_wdata | output | 8 | Peripheral write data |
| ext_rdata | input | 8 | Peripheral read data |

## Verification
Address translation is driven with the same byte offset (0x10) under three values of S and under the stack flag. This separates segment 0, the extension segment and an unmapped segment, and it shows whether the stack flag really forces segment 0. A write aimed at the unmapped segment 2 is followed by a read of the same offset in segment 0. A wrong write-ignore or aliasing would show up there. Decrements walk one register byte through 0x01, 0x00 and 0xFF to check the zero flag and the wrap-around. A write to S directly followed by a lower-half access checks that the new segment is used at once.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_REG  = 2'd1,
    TGT_EXT  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int DW        = 8,
  parameter int EXT_SEG   = 1,
  parameter int BASE_LAST = 'h6F,
  parameter int REG_BASE  = 'hF0
) (
  input  logic [DW-1:0]   addr,
  input  logic            stack,
  input  logic [DW-1:0]   seg_s,
  output logic [2*DW-1:0] phys,
  output tgt_e            tgt,
  output logic [DW-1:0]   ram_idx
);
  localparam int OW = DW - 1;
  logic [DW-1:0] seg;
  logic [OW-1:0] off;

  always_comb begin
    off     = addr[OW-1:0];
    seg     = stack ? '0 : seg_s;
    ram_idx = '0;
    if (addr[DW-1]) begin
      phys = {{DW{1'b0}}, addr};
      tgt  = (int'(addr) >= REG_BASE) ? TGT_REG : TGT_EXT;
    end else begin
      phys = {seg, 1'b0, off};
      if (seg == DW'(EXT_SEG)) begin
        tgt     = TGT_RAM;
        ram_idx = {1'b1, off};
      end else if (seg == '0 && int'(off) <= BASE_LAST) begin
        tgt     = TGT_RAM;
        ram_idx = {1'b0, off};
      end else begin
        tgt = TGT_NONE;
      end
    end
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dmem_regs.sv
module dmem_regs #(
  parameter int DW       = 8,
  parameter int NREG     = 16,
  parameter int SP_RESET = 'h6F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic                    dec,
  input  logic                    stack,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    zero,
  output logic [DW-1:0]           ptr_x,
  output logic [DW-1:0]           ptr_sp,
  output logic [DW-1:0]           ptr_b,
  output logic [DW-1:0]           seg_s
);
  localparam int IW     = $clog2(NREG);
  localparam int SLOT_X = NREG - 4;
  localparam int SLOT_P = NREG - 3;
  localparam int SLOT_B = NREG - 2;
  localparam int SLOT_S = NREG - 1;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] cur, nxt;
  logic          s_guard;

  assign cur     = regs[idx];
  assign nxt     = cur - 1'b1;
  assign s_guard = stack && (idx == IW'(SLOT_S));

  always_ff @(posedge clk) begin
    if (rst) begin
      regs[SLOT_X] <= '0;
      regs[SLOT_P] <= DW'(SP_RESET);
      regs[SLOT_B] <= '0;
      regs[SLOT_S] <= '0;
      zero         <= 1'b0;
      rdata        <= '0;
    end else begin
      if (dec && !s_guard)     regs[idx] <= nxt;
      else if (we && !s_guard) regs[idx] <= wdata;
      zero  <= dec && (nxt == '0);
      rdata <= dec ? nxt : cur;
    end
  end

  assign ptr_x  = regs[SLOT_X];
  assign ptr_sp = regs[SLOT_P];
  assign ptr_b  = regs[SLOT_B];
  assign seg_s  = regs[SLOT_S];

  // R10: the zero flag agrees with the value returned by the decrement
  a_r10_dec_zero: assert property (@(posedge clk) disable iff (rst)
    dec |=> (zero == (rdata == '0)));
  // R3: a stack-type write never alters the segment register
  a_r3_stack_keeps_s: assert property (@(posedge clk) disable iff (rst)
    (we && s_guard) |=> (seg_s == $past(seg_s)));
endmodule

// File: rtl/dmem_seg_ctrl.sv
module dmem_seg_ctrl
  import dmem_pkg::*;
#(
  parameter int DW        = 8,
  parameter int EXT_SEG   = 1,
  parameter int BASE_LAST = 'h6F,
  parameter int REG_BASE  = 'hF0,
  parameter int SP_RESET  = 'h6F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_en,
  input  logic            acc_we,
  input  logic            acc_dec,
  input  logic            acc_stack,
  input  logic [7:0]      acc_addr,
  input  logic [7:0]      acc_wdata,
  output logic [7:0]      rd_data,
  output logic [15:0]     phys_addr,
  output logic            unmapped,
  output logic            dec_zero,
  output logic [7:0]      ptr_x,
  output logic [7:0]      ptr_sp,
  output logic [7:0]      ptr_b,
  output logic [7:0]      seg_s,
  output logic            ext_sel,
  output logic            ext_rd,
  output logic            ext_wr,
  output logic [6:0]      ext_addr,
  output logic [7:0]      ext_wdata,
  input  logic [7:0]      ext_rdata
);
  localparam int NREG = 256 - REG_BASE;
  localparam int IW   = $clog2(NREG);

  tgt_e          tgt, tgt_q;
  logic [15:0]   phys;
  logic [7:0]    ram_idx, ram_q, reg_q, ext_q;
  logic          wr_op, rd_op;

  assign wr_op = acc_en && acc_we && !acc_dec;
  assign rd_op = acc_en && !wr_op;

  dmem_decode #(.DW(DW), .EXT_SEG(EXT_SEG), .BASE_LAST(BASE_LAST), .REG_BASE(REG_BASE)) u_dec (
    .addr(acc_addr), .stack(acc_stack), .seg_s(seg_s),
    .phys(phys), .tgt(tgt), .ram_idx(ram_idx)
  );

  dmem_ram #(.DW(DW), .AW(DW)) u_ram (
    .clk(clk), .we(wr_op && tgt == TGT_RAM), .addr(ram_idx),
    .wdata(acc_wdata), .rdata(ram_q)
  );

  dmem_regs #(.DW(DW), .NREG(NREG), .SP_RESET(SP_RESET)) u_regs (
    .clk(clk), .rst(rst),
    .we(wr_op && tgt == TGT_REG),
    .dec(acc_en && acc_dec && tgt == TGT_REG),
    .stack(acc_stack), .idx(acc_addr[IW-1:0]), .wdata(acc_wdata),
    .rdata(reg_q), .zero(dec_zero),
    .ptr_x(ptr_x), .ptr_sp(ptr_sp), .ptr_b(ptr_b), .seg_s(seg_s)
  );

  assign ext_sel   = acc_en && tgt == TGT_EXT;
  assign ext_rd    = ext_sel && rd_op;
  assign ext_wr    = ext_sel && wr_op;
  assign ext_addr  = acc_addr[6:0];
  assign ext_wdata = acc_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q     <= TGT_NONE;
      phys_addr <= '0;
      unmapped  <= 1'b0;
      ext_q     <= '0;
    end else begin
      tgt_q    <= acc_en ? tgt : TGT_NONE;
      unmapped <= acc_en && tgt == TGT_NONE;
      if (acc_en) phys_addr <= phys;
      if (ext_rd) ext_q <= ext_rdata;
    end
  end

  always_comb begin
    unique case (tgt_q)
      TGT_RAM: rd_data = ram_q;
      TGT_REG: rd_data = reg_q;
      TGT_EXT: rd_data = ext_q;
      default: rd_data = '0;
    endcase
  end

  // R1: lower half, non-stack, is extended by the current segment register
  a_r1_lower_ext: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_addr[7] && !acc_stack) |=>
      (phys_addr == {$past(seg_s), 1'b0, $past(acc_addr[6:0])}));
  // R2: upper half stays in the base page
  a_r2_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_addr[7]) |=> (phys_addr[15:8] == 8'h00));
  // R3: stack accesses resolve into segment 0
  a_r3_stack_seg0: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_stack) |=> (phys_addr[15:8] == 8'h00));
  // R7: an unmapped access reads as zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (rd_data == 8'h00));
  // R8: peripheral strobes only inside the peripheral window
  a_r8_ext_window: assert property (@(posedge clk) disable iff (rst)
    (ext_rd || ext_wr) |-> (acc_addr >= 8'h80 && acc_addr < 8'hF0));
endmodule

// File: tb/sim_dmem_seg_ctrl.sv
module sim_dmem_seg_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic acc_en = 0, acc_we = 0, acc_dec = 0, acc_stack = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0, ext_rdata = 0;
  logic [7:0] rd_data, ptr_x, ptr_sp, ptr_b, seg_s, ext_wdata;
  logic [15:0] phys_addr;
  logic unmapped, dec_zero, ext_sel, ext_rd, ext_wr;
  logic [6:0] ext_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dmem_seg_ctrl u0 (.*);

  typedef struct packed {
    logic we; logic stk; logic [7:0] addr; logic [7:0] wd;
    logic [15:0] phys; logic chk; logic [7:0] rd; logic unm;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,8'hFF,8'h02,16'h00FF,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,8'h10,8'h00,16'h0210,1'b1,8'h00,1'b1},
    '{1'b1,1'b0,8'h10,8'hAA,16'h0210,1'b0,8'h00,1'b1},
    '{1'b1,1'b1,8'h10,8'h55,16'h0010,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,8'hFF,8'h00,16'h00FF,1'b1,8'h02,1'b0},
    '{1'b0,1'b1,8'h05,8'h00,16'h0005,1'b0,8'h00,1'b0},
    '{1'b1,1'b0,8'hFF,8'h01,16'h00FF,1'b0,8'h00,1'b0},
    '{1'b1,1'b0,8'h10,8'h66,16'h0110,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,8'h10,8'h00,16'h0110,1'b1,8'h66,1'b0},
    '{1'b0,1'b1,8'h10,8'h00,16'h0010,1'b1,8'h55,1'b0},
    '{1'b1,1'b0,8'h7F,8'h77,16'h017F,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,8'h7F,8'h00,16'h017F,1'b1,8'h77,1'b0},
    '{1'b1,1'b0,8'hFF,8'h00,16'h00FF,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,8'h70,8'h00,16'h0070,1'b1,8'h00,1'b1},
    '{1'b1,1'b0,8'h6F,8'h3C,16'h006F,1'b0,8'h00,1'b0},
    '{1'b0,1'b0,8'h6F,8'h00,16'h006F,1'b1,8'h3C,1'b0},
    '{1'b0,1'b0,8'h10,8'h00,16'h0010,1'b1,8'h55,1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, return 1 ns after the capturing edge
  task automatic acc(input logic we, input logic dec, input logic stk,
                     input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = we; acc_dec = dec; acc_stack = stk; acc_addr = a; acc_wdata = d;
    @(posedge clk); #1;
    acc_en = 0; acc_we = 0; acc_dec = 0; acc_stack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R5 reset values
    chk("R5 sp", {8'h0, ptr_sp}, 16'h006F);
    chk("R5 x",  {8'h0, ptr_x},  16'h0000);
    chk("R5 b",  {8'h0, ptr_b},  16'h0000);
    chk("R5 s",  {8'h0, seg_s},  16'h0000);

    // table: R1 R2 R3 R6 R7 R9 translation and storage
    for (int i = 0; i < NV; i++) begin
      acc(TBL[i].we, 1'b0, TBL[i].stk, TBL[i].addr, TBL[i].wd);
      chk("R1/R2/R3 phys", phys_addr, TBL[i].phys);
      chk("R7 unmapped", {15'h0, unmapped}, {15'h0, TBL[i].unm});
      if (TBL[i].chk) chk("R6/R7 rd_data", {8'h0, rd_data}, {8'h0, TBL[i].rd});
    end

    // R4 pointer slots
    acc(1, 0, 0, 8'hFC, 8'h11);
    acc(1, 0, 0, 8'hFE, 8'h22);
    acc(1, 0, 0, 8'hFD, 8'h33);
    chk("R4 x",  {8'h0, ptr_x},  16'h0011);
    chk("R4 b",  {8'h0, ptr_b},  16'h0022);
    chk("R4 sp", {8'h0, ptr_sp}, 16'h0033);
    acc(0, 0, 0, 8'hFD, 8'h00);
    chk("R4 read sp", {8'h0, rd_data}, 16'h0033);

    // R3 stack write to S slot is ignored
    acc(1, 0, 1, 8'hFF, 8'h09);
    chk("R3 s kept", {8'h0, seg_s}, 16'h0000);

    // R9 new S used by the very next access
    acc(1, 0, 0, 8'hFF, 8'h01);
    chk("R9 write phys", phys_addr, 16'h00FF);
    acc(0, 0, 0, 8'h00, 8'h00);
    chk("R9 next phys", phys_addr, 16'h0100);
    acc(1, 0, 0, 8'hFF, 8'h00);

    // R8 peripheral window
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = 8'h85; acc_wdata = 8'h5A; #1;
    chk("R8 wr strobe", {13'h0, ext_sel, ext_wr, ext_rd}, 16'h0006);
    chk("R8 addr", {9'h0, ext_addr}, 16'h0005);
    chk("R8 wdata", {8'h0, ext_wdata}, 16'h005A);
    acc_we = 0; acc_addr = 8'hEF; ext_rdata = 8'hC3; #1;
    chk("R8 rd strobe", {13'h0, ext_sel, ext_wr, ext_rd}, 16'h0005);
    @(posedge clk); #1; acc_en = 0;
    chk("R8 rdata", {8'h0, rd_data}, 16'h00C3);
    @(negedge clk); acc_en = 1; acc_addr = 8'hF0; #1;
    chk("R8 no sel at F0", {15'h0, ext_sel}, 16'h0000);
    @(posedge clk); #1; acc_en = 0;

    // R10 decrement with wrap
    acc(1, 0, 0, 8'hF3, 8'h02);
    acc(0, 1, 0, 8'hF3, 8'h00);
    chk("R10 val 1", {8'h0, rd_data}, 16'h0001);
    chk("R10 zero 0", {15'h0, dec_zero}, 16'h0000);
    acc(0, 1, 0, 8'hF3, 8'h00);
    chk("R10 val 0", {8'h0, rd_data}, 16'h0000);
    chk("R10 zero 1", {15'h0, dec_zero}, 16'h0001);
    acc(0, 1, 0, 8'hF3, 8'h00);
    chk("R10 wrap", {8'h0, rd_data}, 16'h00FF);
    chk("R10 zero wrap", {15'h0, dec_zero}, 16'h0000);

    // R11 decrement of RAM is a read
    acc(1, 0, 0, 8'h20, 8'h01);
    acc(0, 1, 0, 8'h20, 8'h00);
    chk("R11 zero", {15'h0, dec_zero}, 16'h0000);
    chk("R11 read", {8'h0, rd_data}, 16'h0001);
    acc(0, 0, 0, 8'h20, 8'h00);
    chk("R11 unchanged", {8'h0, rd_data}, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule